// File: doc/BRIEF.md
# Single-channel DMA transfer controller

This block moves a block of data between one peripheral data port and system memory, so the processor does not have to copy each item itself. Software loads a start address and a length in bytes, then writes a control word. The control word picks the direction, the transfer unit (byte or 16-bit word), the bus arbitration mode and an optional burst limit. The same write can set a start bit that launches the transfer.

Once running, the engine waits for the peripheral to signal that it has data ready. It then asks for the memory bus with a hold request and waits for the acknowledge. Only after that does it drive the address, byte enables and one read or write strobe. Data passes straight between the peripheral and memory in the same cycle.

In cycle-stealing mode the engine hands the bus back after every unit. In burst mode it keeps the bus across units, either for the whole block or until a programmed number of bytes has moved. When the count reaches zero, the engine raises an interrupt. The interrupt stays up until software clears it.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, busy, irq, hold_req, mem_rd, mem_wr and per_ack are 0, and the address, count and control registers read as 0.
- R2: Register select 0 is the memory address and select 1 is the byte count. Select 2 is control: bit0 direction, bit1 unit (1 = word), bit2 mode (1 = burst), bits 15:8 burst length in bytes. Bit3 (start) and bit4 (interrupt clear) of control are write-only and read as 0. Select 3 is status: bit0 busy, bit1 irq.
- R3: While busy, writes to the address, count and control fields are ignored. A start request is ignored when the stored count is zero.
- R4: hold_req rises only while busy and per_req is high. mem_rd or mem_wr is asserted only while both hold_req and hold_ack are high.
- R5: With direction 0 (peripheral to memory), each unit pulses mem_wr and drives per_rdata onto mem_wdata. With direction 1 (memory to peripheral), each unit pulses mem_rd and drives mem_rdata onto per_wdata. Every unit pulses per_ack in the same cycle as the strobe.
- R6: In word mode the address steps by 2 and mem_be is 11. In byte mode the address steps by 1 and mem_be is 01 for an even address and 10 for an odd one. A written byte is replicated on both lanes; a read byte is taken from the selected lane into per_wdata[7:0], with the upper bits zero.
- R7: The count drops by the smaller of the step and the remaining count. The transfer ends with count 0 and busy low.
- R8: In cycle-stealing mode, hold_req drops after every unit and stays low for at least one cycle before the next request.
- R9: In burst mode, hold_req stays high between units. With a nonzero burst length, the bus is released once that many bytes have moved under the current grant. With burst length 0, the bus is held for the whole block.
- R10: The last unit sets irq. irq stays high until a control write with bit4 set, and busy reads 1 from start until the last unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register read data |
| hold_req | output | 1 | Bus hold request to processor/arbiter |
| hold_ack | input | 1 | Bus hold acknowledge |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 2 | Memory byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid during mem_rd |
| per_req | input | 1 | Peripheral data-ready request |
| per_ack | output | 1 | Peripheral unit acknowledge |
| per_rdata | input | 16 | Data from peripheral |
| per_wdata | output | 16 | Data to peripheral |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The assertions check several rules on every cycle:
- a strobe never appears without a granted hold;
- read and write are exclusive, and every acknowledge carries exactly one strobe;
- the address steps by the unit size after each transfer;
- cycle-stealing releases the bus after each unit, with at least one idle cycle;
- the interrupt stays set until cleared, and busy falls only with a zero count and irq set.

The bench scenarios show what a per-cycle property cannot: the exact address, lane and data sequence of a whole block, and the number of bus grants per block in each mode and burst length. They also show that register writes during a transfer and a start with zero count have no effect, and the final register values read back.

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int BLW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          per_req,
  output logic          per_ack,
  input  logic [15:0]   per_rdata,
  output logic [15:0]   per_wdata,
  output logic          irq
);
  localparam int BCW = BLW + 1;

  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  cnt_q;
  logic [BLW-1:0] blen_q;
  logic [BCW-1:0] bcnt_q;
  logic dir_q, unit_q, burst_q;
  logic busy_q, irq_q, hold_q, rel_q;

  wire ctl_wr   = reg_wr && reg_sel == 2'd2;
  wire wr_addr  = reg_wr && reg_sel == 2'd0 && !busy_q;
  wire wr_cnt   = reg_wr && reg_sel == 2'd1 && !busy_q;
  wire wr_ctl   = ctl_wr && !busy_q;
  wire start    = wr_ctl && reg_wdata[3] && cnt_q != '0;
  wire clr      = ctl_wr && reg_wdata[4];

  wire [1:0]     step  = unit_q ? 2'd2 : 2'd1;
  wire           xfer  = busy_q && hold_q && hold_ack && per_req;
  wire           last  = cnt_q <= CW'(step);
  wire [BCW-1:0] bnext = bcnt_q + BCW'(step);
  wire           bend  = burst_q && blen_q != '0 && bnext >= {1'b0, blen_q};
  wire           drop  = last || !burst_q || bend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      blen_q  <= '0;
      bcnt_q  <= '0;
      dir_q   <= 1'b0;
      unit_q  <= 1'b0;
      burst_q <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
      hold_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      if (wr_addr) addr_q <= reg_wdata[AW-1:0];
      if (wr_cnt)  cnt_q  <= reg_wdata[CW-1:0];
      if (wr_ctl) begin
        dir_q   <= reg_wdata[0];
        unit_q  <= reg_wdata[1];
        burst_q <= reg_wdata[2];
        blen_q  <= reg_wdata[8 +: BLW];
      end
      if (start) busy_q <= 1'b1;

      if (xfer) begin
        addr_q <= addr_q + AW'(step);
        cnt_q  <= last ? '0 : cnt_q - CW'(step);
        if (drop) begin
          hold_q <= 1'b0;
          rel_q  <= 1'b1;
          bcnt_q <= '0;
        end else begin
          bcnt_q <= bnext;
        end
        if (last) busy_q <= 1'b0;
      end else if (busy_q && !hold_q && !rel_q && per_req) begin
        hold_q <= 1'b1;
      end

      if (xfer && last) irq_q <= 1'b1;
      else if (clr)     irq_q <= 1'b0;
    end
  end

  wire [7:0] rd_byte = addr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  assign hold_req  = hold_q;
  assign mem_addr  = addr_q;
  assign mem_wr    = xfer && !dir_q;
  assign mem_rd    = xfer && dir_q;
  assign per_ack   = xfer;
  assign mem_be    = unit_q ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);
  assign mem_wdata = unit_q ? per_rdata : {2{per_rdata[7:0]}};
  assign per_wdata = unit_q ? mem_rdata : {8'h00, rd_byte};
  assign irq       = irq_q;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = 16'(addr_q);
      2'd1:    reg_rdata = 16'(cnt_q);
      2'd2:    reg_rdata = 16'({blen_q, 5'b0, burst_q, unit_q, dir_q});
      default: reg_rdata = {14'b0, irq_q, busy_q};
    endcase
  end
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_req,
  input logic          hold_ack,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          per_ack,
  input logic [AW-1:0] mem_addr,
  input logic          unit,
  input logic          burst,
  input logic          busy,
  input logic          irq,
  input logic          clr,
  input logic [CW-1:0] cnt
);
  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (hold_req && hold_ack)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> (mem_rd ^ mem_wr)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> (mem_addr == $past(mem_addr) + AW'($past(unit) ? 2 : 1))); // R6
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack && !burst) |=> !hold_req); // R8
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |=> !hold_req); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq); // R10
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cnt == '0 && irq)); // R7
  AST_XFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> busy); // R7
endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .per_ack(per_ack), .mem_addr(mem_addr),
  .unit(unit_q), .burst(burst_q), .busy(busy_q), .irq(irq_q), .clr(clr),
  .cnt(cnt_q)
);

// File: tb/tb_dma_ctrl.sv
`timescale 1ns/1ps
module tb_dma_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic hold_req, hold_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, per_rdata, per_wdata;
  logic mem_rd, mem_wr, per_ack, irq, per_en = 1'b0;
  logic [1:0] mem_be;
  int pidx = 0, grants = 0, n_chk = 0, n_bad = 0;
  logic hreq_q = 1'b0;

  typedef struct packed {
    logic        wr;
    logic [15:0] a;
    logic [1:0]  be;
    logic [15:0] d;
  } item_t;
  item_t exp_q[$];

  dma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hold_req(hold_req),
    .hold_ack(hold_ack), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .per_req(per_en), .per_ack(per_ack), .per_rdata(per_rdata),
    .per_wdata(per_wdata), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {~a[7:0], a[7:0]};
  endfunction

  assign mem_rdata = memf(mem_addr);
  assign per_rdata = 16'h1000 + 16'(pidx);

  always @(posedge clk) begin
    hold_ack <= rst_n && hold_req;
    hreq_q   <= hold_req;
    if (hold_req && !hreq_q) grants <= grants + 1;
    if (!rst_n) pidx <= 0;
    else if (per_ack) pidx <= pidx + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R5 actual=unexpected strobe at %h expected=none", mem_addr);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check("R5 dir", {31'd0, mem_wr}, {31'd0, it.wr});
        check("R6 addr", {16'd0, mem_addr}, {16'd0, it.a});
        check("R6 be", {30'd0, mem_be}, {30'd0, it.be});
        check("R5 data", {16'd0, it.wr ? mem_wdata : per_wdata}, {16'd0, it.d});
        check("R5 ack", {31'd0, per_ack}, 32'd1);
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk); reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic run(input logic dir, input logic unit, input logic burst,
                     input logic [7:0] blen, input logic [15:0] a0,
                     input logic [15:0] n, input int exp_g, input string tag,
                     input logic hold_off);
    logic [15:0] a, rem, v, d;
    int k, g0, t;
    a = a0; rem = n; k = 0;
    while (rem != 0) begin
      item_t it;
      d = 16'h1000 + 16'(pidx + k);
      it.wr = !dir;
      it.a  = a;
      it.be = unit ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
      if (!dir) it.d = unit ? d : {d[7:0], d[7:0]};
      else      it.d = unit ? memf(a) : {8'h00, a[0] ? memf(a)[15:8] : memf(a)[7:0]};
      exp_q.push_back(it);
      a   = a + (unit ? 16'd2 : 16'd1);
      rem = (rem > (unit ? 16'd2 : 16'd1)) ? rem - (unit ? 16'd2 : 16'd1) : 16'd0;
      k++;
    end
    per_en = !hold_off;
    g0 = grants;
    wr(2'd0, a0);
    wr(2'd1, n);
    wr(2'd2, {blen, 4'b0, 1'b1, burst, unit, dir});
    if (hold_off) begin
      repeat (4) @(negedge clk);
      check("R4 no request without per_req", {31'd0, hold_req}, 32'd0);
      rd(2'd3, v);
      check("R10 busy during transfer", {16'd0, v}, 32'h1);
      wr(2'd0, 16'h0999);
      wr(2'd1, 16'h0077);
      rd(2'd0, v);
      check("R3 addr write ignored while busy", {16'd0, v}, {16'd0, a0});
      rd(2'd1, v);
      check("R3 count write ignored while busy", {16'd0, v}, {16'd0, n});
      per_en = 1'b1;
    end
    t = 0;
    do begin rd(2'd3, v); t++; end while (v[0] && t < 2000);
    per_en = 1'b0;
    repeat (3) @(negedge clk);
    check({tag, " queue drained"}, exp_q.size(), 0);
    rd(2'd0, v);
    check({tag, " R6 final addr"}, {16'd0, v}, {16'd0, a});
    rd(2'd1, v);
    check({tag, " R7 count zero"}, {16'd0, v}, 32'd0);
    rd(2'd3, v);
    check({tag, " R10 irq set, not busy"}, {16'd0, v}, 32'h2);
    check({tag, " R8/R9 grants"}, grants - g0, exp_g);
    exp_q.delete();
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R1 hold_req", {31'd0, hold_req}, 0);
    check("R1 strobes", {29'd0, mem_rd, mem_wr, per_ack}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      check("R1 register reset", {16'd0, v}, 0);
    end
    wr(2'd2, 16'hAB1F);
    rd(2'd2, v);
    check("R2 control readback, start/clear read 0", {16'd0, v}, 32'hAB07);
    rd(2'd3, v);
    check("R3 start ignored with zero count", {16'd0, v}, 0);
    wr(2'd0, 16'h1234);
    rd(2'd0, v);
    check("R2 address readback", {16'd0, v}, 32'h1234);

    run(1'b0, 1'b1, 1'b0, 8'd0, 16'h0100, 16'd6, 3, "A word steal wr", 1'b1);
    repeat (5) @(negedge clk);
    check("R10 irq held", {31'd0, irq}, 1);
    wr(2'd2, 16'h0010);
    check("R10 irq cleared", {31'd0, irq}, 0);

    run(1'b1, 1'b0, 1'b1, 8'd0, 16'h0201, 16'd3, 1, "B byte burst rd R9", 1'b0);
    wr(2'd2, 16'h0010);
    run(1'b0, 1'b0, 1'b1, 8'd2, 16'h0300, 16'd5, 3, "C byte burst2 wr R9", 1'b0);
    wr(2'd2, 16'h0010);
    run(1'b1, 1'b1, 1'b0, 8'd0, 16'h0400, 16'd3, 2, "D word odd count R7", 1'b0);
    wr(2'd2, 16'h0010);
    run(1'b0, 1'b1, 1'b1, 8'd4, 16'h0500, 16'd10, 3, "E word burst4 R9", 1'b0);
    finish_up();
  end
endmodule